// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

The selector sits between the ready queues of an out-of-order core and its execution pipes. Six ready queues feed it: integer, floating-point, branch, memory, miscellaneous, and a drain queue that holds entries which were squashed after they entered the window. Each queue shows the selector its first few entries. Each entry carries a valid bit, a sequence number and a squashed flag. In one clock cycle the selector runs a fixed chain of selection steps. Each step either throws away one squashed head or moves the oldest eligible head into the next free issue slot.

Four of the classes (integer, floating-point, branch, memory) each have their own cap per cycle. The miscellaneous and drain classes are bounded only by the total issue width. The selector reports how many entries to pop from each queue, the filled issue slots with their class and sequence number, the number of issues per class, the number of discarded squashed heads, and the number of window entries freed. A small side path maps the type flags of a ready instruction to the queue it belongs in. All outputs are registered. The queues apply the pops before the next cycle's selection.

Top module: `issel_top`

## Requirements
- R1: While reset is high, every output is zero after the clock edge.
- R2: No more than ISSUE_W instructions are issued in a cycle. Issue slots fill from index 0 upward with no gaps. free_inc equals the number of instructions issued, and it also equals the sum of the per-class counts.
- R3: Each selection step issues the eligible head with the smallest sequence number, compared as unsigned. Slots hold the winners in step order.
- R4: When sequence numbers are equal, the earlier queue wins. The order is integer (code 0), floating-point (1), branch (2), memory (3), miscellaneous (4), drain (5).
- R5: The integer, floating-point, branch and memory queues each issue at most their own limit per cycle. The limit for class c sits in class_lim bits [c*CNT_W +: CNT_W]. A limit of zero blocks the class.
- R6: The miscellaneous and drain queues have no per-class cap. Only the total width limits them.
- R7: A step first checks the eligible heads of queues 0 to 4. If any of them is squashed, the lowest-numbered such head is popped without being issued. This counts one in stall_cnt and uses no issue width. A cycle runs at most STEPS steps, and each queue exposes at most LOOK entries.
- R8: An entry from the drain queue takes an issue slot with class code 5 and counts toward the total width. Its squashed flag is ignored.
- R9: A head whose sequence number is all ones is never issued.
- R10: The type router gives priority to control (branch queue, 2), then memory reference (3), then integer (0), then floating-point (1). Any other instruction goes to miscellaneous (4).
- R11: Outputs show the inputs that were sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hd_vld | input | NQ*LOOK | Entry valid, at index q*LOOK+k for queue q, position k |
| hd_seq | input | NQ*LOOK*SEQ_W | Entry sequence numbers, in the same index order |
| hd_sqs | input | NQ*LOOK | Entry squashed flags, in the same index order |
| class_lim | input | 4*CNT_W | Per-cycle caps for classes 0 to 3 |
| rt_ctrl | input | 1 | Router: instruction is control |
| rt_mem | input | 1 | Router: instruction references memory |
| rt_int | input | 1 | Router: integer instruction |
| rt_fp | input | 1 | Router: floating-point instruction |
| pop_cnt | output | NQ*PTR_W | Entries to pop per queue |
| slot_vld | output | ISSUE_W | Issue slot occupied |
| slot_cls | output | ISSUE_W*3 | Class code per slot |
| slot_seq | output | ISSUE_W*SEQ_W | Sequence number per slot |
| cls_cnt | output | NQ*CNT_W | Issues per class this cycle |
| stall_cnt | output | STL_W | Squashed heads discarded this cycle |
| free_inc | output | CNT_W | Window entries freed this cycle |
| rt_cls | output | 3 | Router's target queue code |

## Verification
Hand-built queue contents isolate one rule at a time: equal ages across classes show the tie order, a class cap of zero is set against an unlimited class, heads are loaded with the sentinel sequence number, a squashed run sits ahead of a live entry, and a drain entry is older than a ready one. A long sweep then refills all six queues with random ages, random squash flags and occasional sentinels, and varies the caps. Every pop count, slot, class count and stall count is compared with an arithmetic model of the step chain. This separates age ordering from queue order, and separates per-class caps from the total width. The router is swept over all sixteen flag combinations.

// File: rtl/issel_pkg.sv
package issel_pkg;
  localparam int NQ    = 6;  // number of ready queues
  localparam int NLIM  = 4;  // queues with a per-class cap
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT   = 3'd0,
    CLS_FP    = 3'd1,
    CLS_BR    = 3'd2,
    CLS_MEM   = 3'd3,
    CLS_MISC  = 3'd4,
    CLS_DRAIN = 3'd5
  } cls_e;
endpackage

// File: rtl/issel_route.sv
module issel_route
  import issel_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             is_ctrl,
  input  logic             is_mem,
  input  logic             is_int,
  input  logic             is_fp,
  output logic [CLS_W-1:0] cls_q
);
  cls_e pick;

  always_comb begin
    if (is_ctrl)     pick = CLS_BR;
    else if (is_mem) pick = CLS_MEM;
    else if (is_int) pick = CLS_INT;
    else if (is_fp)  pick = CLS_FP;
    else             pick = CLS_MISC;
  end

  always_ff @(posedge clk) begin
    if (rst) cls_q <= '0;
    else     cls_q <= pick;
  end

  // R10: control outranks every other flag
  assert_ctrl_first_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(is_ctrl)) |-> (cls_q == CLS_BR));
  // R10: memory outranks integer and floating-point
  assert_mem_second_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(is_ctrl) && $past(is_mem)) |-> (cls_q == CLS_MEM));
endmodule

// File: rtl/issel_step.sv
module issel_step
  import issel_pkg::*;
#(
  parameter int SEQ_W   = 8,
  parameter int ISSUE_W = 4,
  parameter int CNT_W   = 3
) (
  input  logic [NQ-1:0]        h_vld,
  input  logic [NQ*SEQ_W-1:0]  h_seq,
  input  logic [NQ-1:0]        h_sqs,
  input  logic [NQ*CNT_W-1:0]  cnt,
  input  logic [NLIM*CNT_W-1:0] lim,
  input  logic [CNT_W-1:0]     tot,
  output logic                 take_dis,
  output logic                 take_iss,
  output logic [CLS_W-1:0]     take_q,
  output logic [SEQ_W-1:0]     take_seq
);
  localparam logic [CNT_W-1:0] WIDTH_C = CNT_W'(ISSUE_W);

  logic [NQ-1:0]    elig;
  logic [SEQ_W-1:0] best;
  logic             found;
  logic [CLS_W-1:0] win;
  logic [CLS_W-1:0] dq;
  logic             dfound;

  // eligibility: open width, valid head, class under its cap
  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      if (q < NLIM)
        elig[q] = (tot < WIDTH_C) && h_vld[q] &&
                  (cnt[q*CNT_W +: CNT_W] < lim[(q % NLIM)*CNT_W +: CNT_W]);
      else
        elig[q] = (tot < WIDTH_C) && h_vld[q];
    end
  end

  // lowest-numbered squashed head among the five normal queues
  always_comb begin
    dfound = 1'b0;
    dq     = '0;
    for (int q = NQ-2; q >= 0; q--) begin
      if (elig[q] && h_sqs[q]) begin
        dfound = 1'b1;
        dq     = CLS_W'(q);
      end
    end
  end

  // oldest head, strict less-than in queue order, sentinel never wins
  always_comb begin
    best  = '1;
    found = 1'b0;
    win   = '0;
    for (int q = 0; q < NQ; q++) begin
      if (elig[q] && (h_seq[q*SEQ_W +: SEQ_W] < best)) begin
        best  = h_seq[q*SEQ_W +: SEQ_W];
        found = 1'b1;
        win   = CLS_W'(q);
      end
    end
  end

  always_comb begin
    take_dis = dfound;
    take_iss = !dfound && found;
    take_q   = dfound ? dq : win;
    take_seq = best;
  end
endmodule

// File: rtl/issel_top.sv
module issel_top
  import issel_pkg::*;
#(
  parameter int SEQ_W   = 8,
  parameter int ISSUE_W = 4,
  parameter int LOOK    = 4,
  parameter int STEPS   = 8,
  localparam int CNT_W  = $clog2(ISSUE_W+1),
  localparam int PTR_W  = $clog2(LOOK+1),
  localparam int STL_W  = $clog2(STEPS+1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NQ*LOOK-1:0]         hd_vld,
  input  logic [NQ*LOOK*SEQ_W-1:0]   hd_seq,
  input  logic [NQ*LOOK-1:0]         hd_sqs,
  input  logic [NLIM*CNT_W-1:0]      class_lim,
  input  logic                       rt_ctrl,
  input  logic                       rt_mem,
  input  logic                       rt_int,
  input  logic                       rt_fp,
  output logic [NQ*PTR_W-1:0]        pop_cnt,
  output logic [ISSUE_W-1:0]         slot_vld,
  output logic [ISSUE_W*CLS_W-1:0]   slot_cls,
  output logic [ISSUE_W*SEQ_W-1:0]   slot_seq,
  output logic [NQ*CNT_W-1:0]        cls_cnt,
  output logic [STL_W-1:0]           stall_cnt,
  output logic [CNT_W-1:0]           free_inc,
  output logic [CLS_W-1:0]           rt_cls
);
  // state carried between selection steps
  logic [NQ*PTR_W-1:0] ptr_v [STEPS+1];
  logic [NQ*CNT_W-1:0] cnt_v [STEPS+1];
  logic [CNT_W-1:0]    tot_v [STEPS+1];
  logic [STL_W-1:0]    stl_v [STEPS+1];
  logic                st_iss [STEPS];
  logic [CLS_W-1:0]    st_q   [STEPS];
  logic [SEQ_W-1:0]    st_seq [STEPS];

  assign ptr_v[0] = '0;
  assign cnt_v[0] = '0;
  assign tot_v[0] = '0;
  assign stl_v[0] = '0;

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    logic [NQ-1:0]       hv;
    logic [NQ-1:0]       hs;
    logic [NQ*SEQ_W-1:0] hq;
    logic                dis;
    logic                iss;
    logic [CLS_W-1:0]    tq;
    logic [SEQ_W-1:0]    tseq;
    logic [NQ*PTR_W-1:0] np;
    logic [NQ*CNT_W-1:0] nc;
    logic [CNT_W-1:0]    nt;
    logic [STL_W-1:0]    nl;

    // current head of each queue behind what earlier steps consumed
    always_comb begin
      for (int q = 0; q < NQ; q++) begin
        int p;
        p = int'(ptr_v[s][q*PTR_W +: PTR_W]);
        if (p < LOOK) begin
          hv[q] = hd_vld[q*LOOK + p];
          hs[q] = hd_sqs[q*LOOK + p];
          hq[q*SEQ_W +: SEQ_W] = hd_seq[(q*LOOK + p)*SEQ_W +: SEQ_W];
        end else begin
          hv[q] = 1'b0;
          hs[q] = 1'b0;
          hq[q*SEQ_W +: SEQ_W] = '1;
        end
      end
    end

    issel_step #(
      .SEQ_W(SEQ_W), .ISSUE_W(ISSUE_W), .CNT_W(CNT_W)
    ) i_step (
      .h_vld(hv), .h_seq(hq), .h_sqs(hs),
      .cnt(cnt_v[s]), .lim(class_lim), .tot(tot_v[s]),
      .take_dis(dis), .take_iss(iss), .take_q(tq), .take_seq(tseq)
    );

    always_comb begin
      np = ptr_v[s];
      nc = cnt_v[s];
      nt = tot_v[s];
      nl = stl_v[s];
      if (dis || iss)
        np[int'(tq)*PTR_W +: PTR_W] = np[int'(tq)*PTR_W +: PTR_W] + PTR_W'(1);
      if (dis)
        nl = nl + STL_W'(1);
      if (iss) begin
        nc[int'(tq)*CNT_W +: CNT_W] = nc[int'(tq)*CNT_W +: CNT_W] + CNT_W'(1);
        nt = nt + CNT_W'(1);
      end
    end

    assign ptr_v[s+1] = np;
    assign cnt_v[s+1] = nc;
    assign tot_v[s+1] = nt;
    assign stl_v[s+1] = nl;
    assign st_iss[s]  = iss;
    assign st_q[s]    = tq;
    assign st_seq[s]  = tseq;
  end

  // scatter the winners into slots by their issue index
  logic [ISSUE_W-1:0]       n_vld;
  logic [ISSUE_W*CLS_W-1:0] n_cls;
  logic [ISSUE_W*SEQ_W-1:0] n_seq;

  always_comb begin
    n_vld = '0;
    n_cls = '0;
    n_seq = '0;
    for (int s = 0; s < STEPS; s++) begin
      if (st_iss[s]) begin
        n_vld[int'(tot_v[s])] = 1'b1;
        n_cls[int'(tot_v[s])*CLS_W +: CLS_W] = st_q[s];
        n_seq[int'(tot_v[s])*SEQ_W +: SEQ_W] = st_seq[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_cnt   <= '0;
      slot_vld  <= '0;
      slot_cls  <= '0;
      slot_seq  <= '0;
      cls_cnt   <= '0;
      stall_cnt <= '0;
      free_inc  <= '0;
    end else begin
      pop_cnt   <= ptr_v[STEPS];
      slot_vld  <= n_vld;
      slot_cls  <= n_cls;
      slot_seq  <= n_seq;
      cls_cnt   <= cnt_v[STEPS];
      stall_cnt <= stl_v[STEPS];
      free_inc  <= tot_v[STEPS];
    end
  end

  issel_route i_route (
    .clk(clk), .rst(rst),
    .is_ctrl(rt_ctrl), .is_mem(rt_mem), .is_int(rt_int), .is_fp(rt_fp),
    .cls_q(rt_cls)
  );

  // ---- checks on the registered outputs ----
  int pop_sum;
  int cls_sum;
  always_comb begin
    pop_sum = 0;
    cls_sum = 0;
    for (int q = 0; q < NQ; q++) begin
      pop_sum += int'(pop_cnt[q*PTR_W +: PTR_W]);
      cls_sum += int'(cls_cnt[q*CNT_W +: CNT_W]);
    end
  end

  // R2: slots contiguous from index 0, and as many as entries freed
  assert_slots_packed_R2: assert property (@(posedge clk) disable iff (rst)
    slot_vld == ISSUE_W'((1 << free_inc) - 1));
  // R2: per-class counts add up to the freed entries
  assert_count_sum_R2: assert property (@(posedge clk) disable iff (rst)
    cls_sum == int'(free_inc));
  // R7: every pop is either an issue or a discarded squashed head
  assert_pop_balance_R7: assert property (@(posedge clk) disable iff (rst)
    pop_sum == int'(stall_cnt) + int'(free_inc));
  // R8: drain entries are never discarded, only issued
  assert_drain_issued_R8: assert property (@(posedge clk) disable iff (rst)
    pop_cnt[(NQ-1)*PTR_W +: PTR_W] == PTR_W'(cls_cnt[(NQ-1)*CNT_W +: CNT_W]));

  for (genvar c = 0; c < NLIM; c++) begin : g_cap_chk
    // R5: class never exceeds the cap it saw
    assert_class_cap_R5: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (cls_cnt[c*CNT_W +: CNT_W] <= $past(class_lim[c*CNT_W +: CNT_W])));
  end

  for (genvar i = 0; i < ISSUE_W; i++) begin : g_seq_chk
    // R9: the sentinel sequence number never reaches a slot
    assert_no_sentinel_R9: assert property (@(posedge clk) disable iff (rst)
      slot_vld[i] |-> (slot_seq[i*SEQ_W +: SEQ_W] != '1));
  end
endmodule

// File: tb/test_issel_top.sv
module test_issel_top;
  import issel_pkg::*;

  localparam int SEQ_W   = 8;
  localparam int ISSUE_W = 4;
  localparam int LOOK    = 4;
  localparam int STEPS   = 8;
  localparam int CNT_W   = $clog2(ISSUE_W+1);
  localparam int PTR_W   = $clog2(LOOK+1);
  localparam int STL_W   = $clog2(STEPS+1);
  localparam int QMAX    = 16;
  localparam int SENT    = (1 << SEQ_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NQ*LOOK-1:0]       hd_vld = '0;
  logic [NQ*LOOK*SEQ_W-1:0] hd_seq = '0;
  logic [NQ*LOOK-1:0]       hd_sqs = '0;
  logic [NLIM*CNT_W-1:0]    class_lim = '0;
  logic rt_ctrl = 1'b0, rt_mem = 1'b0, rt_int = 1'b0, rt_fp = 1'b0;
  logic [NQ*PTR_W-1:0]      pop_cnt;
  logic [ISSUE_W-1:0]       slot_vld;
  logic [ISSUE_W*CLS_W-1:0] slot_cls;
  logic [ISSUE_W*SEQ_W-1:0] slot_seq;
  logic [NQ*CNT_W-1:0]      cls_cnt;
  logic [STL_W-1:0]         stall_cnt;
  logic [CNT_W-1:0]         free_inc;
  logic [CLS_W-1:0]         rt_cls;

  issel_top #(.SEQ_W(SEQ_W), .ISSUE_W(ISSUE_W), .LOOK(LOOK), .STEPS(STEPS)) i_issel_top (
    .clk(clk), .rst(rst), .hd_vld(hd_vld), .hd_seq(hd_seq), .hd_sqs(hd_sqs),
    .class_lim(class_lim), .rt_ctrl(rt_ctrl), .rt_mem(rt_mem), .rt_int(rt_int),
    .rt_fp(rt_fp), .pop_cnt(pop_cnt), .slot_vld(slot_vld), .slot_cls(slot_cls),
    .slot_seq(slot_seq), .cls_cnt(cls_cnt), .stall_cnt(stall_cnt),
    .free_inc(free_inc), .rt_cls(rt_cls)
  );

  always #5 clk = ~clk;

  int nchk = 0;
  int nerr = 0;

  // bench-side queue storage
  int qs   [NQ][QMAX];
  bit qsq  [NQ][QMAX];
  int qlen [NQ];
  int lim  [NLIM];

  // expected results
  int e_pop [NQ];
  int e_cnt [NQ];
  int e_stl, e_tot;
  int e_svld [ISSUE_W];
  int e_scls [ISSUE_W];
  int e_sseq [ISSUE_W];

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_queues();
    for (int q = 0; q < NQ; q++) qlen[q] = 0;
  endtask

  task automatic push(int q, int seq, bit sq);
    if (qlen[q] < QMAX) begin
      qs[q][qlen[q]]  = seq;
      qsq[q][qlen[q]] = sq;
      qlen[q]++;
    end
  endtask

  task automatic present();
    for (int q = 0; q < NQ; q++)
      for (int k = 0; k < LOOK; k++) begin
        hd_vld[q*LOOK+k] = (k < qlen[q]);
        hd_seq[(q*LOOK+k)*SEQ_W +: SEQ_W] = (k < qlen[q]) ? SEQ_W'(qs[q][k]) : '0;
        hd_sqs[q*LOOK+k] = (k < qlen[q]) ? qsq[q][k] : 1'b0;
      end
    for (int c = 0; c < NLIM; c++) class_lim[c*CNT_W +: CNT_W] = CNT_W'(lim[c]);
  endtask

  // arithmetic model of one cycle from the requirements
  task automatic model();
    int ptr [NQ];
    for (int q = 0; q < NQ; q++) begin ptr[q] = 0; e_cnt[q] = 0; end
    for (int i = 0; i < ISSUE_W; i++) begin e_svld[i] = 0; e_scls[i] = 0; e_sseq[i] = 0; end
    e_stl = 0; e_tot = 0;
    for (int s = 0; s < STEPS; s++) begin
      bit el [NQ];
      int dq, best, win;
      for (int q = 0; q < NQ; q++)
        el[q] = (e_tot < ISSUE_W) && (ptr[q] < LOOK) && (ptr[q] < qlen[q]) &&
                (q >= NLIM || e_cnt[q] < lim[q]);
      dq = -1;
      for (int q = 0; q < NQ-1; q++)
        if (dq < 0 && el[q] && qsq[q][ptr[q]]) dq = q;
      if (dq >= 0) begin
        ptr[dq]++; e_stl++;
      end else begin
        best = SENT; win = -1;
        for (int q = 0; q < NQ; q++)
          if (el[q] && qs[q][ptr[q]] < best) begin best = qs[q][ptr[q]]; win = q; end
        if (win >= 0) begin
          e_svld[e_tot] = 1; e_scls[e_tot] = win; e_sseq[e_tot] = best;
          ptr[win]++; e_cnt[win]++; e_tot++;
        end
      end
    end
    for (int q = 0; q < NQ; q++) e_pop[q] = ptr[q];
  endtask

  task automatic compare();
    for (int q = 0; q < NQ; q++) begin
      chk("R7", $sformatf("pop q%0d", q), int'(pop_cnt[q*PTR_W +: PTR_W]), e_pop[q]);
      chk(q < NLIM ? "R5" : "R6", $sformatf("cls_cnt %0d", q), int'(cls_cnt[q*CNT_W +: CNT_W]), e_cnt[q]);
    end
    chk("R7", "stall_cnt", int'(stall_cnt), e_stl);
    chk("R2", "free_inc", int'(free_inc), e_tot);
    for (int i = 0; i < ISSUE_W; i++) begin
      chk("R2", $sformatf("slot_vld %0d", i), int'(slot_vld[i]), e_svld[i]);
      if (e_svld[i] != 0) begin
        chk("R8", $sformatf("slot_cls %0d", i), int'(slot_cls[i*CLS_W +: CLS_W]), e_scls[i]);
        chk("R3", $sformatf("slot_seq %0d", i), int'(slot_seq[i*SEQ_W +: SEQ_W]), e_sseq[i]);
      end
    end
  endtask

  task automatic apply_pops();
    for (int q = 0; q < NQ; q++)
      for (int n = 0; n < e_pop[q]; n++) begin
        for (int k = 0; k < QMAX-1; k++) begin
          qs[q][k] = qs[q][k+1]; qsq[q][k] = qsq[q][k+1];
        end
        qlen[q]--;
      end
  endtask

  // one full cycle: drive, clock, compare, consume
  task automatic run_cycle();
    present();
    model();
    @(posedge clk); #1;
    compare();
    apply_pops();
  endtask

  task automatic set_lim(int a, int b, int c, int d);
    lim[0] = a; lim[1] = b; lim[2] = c; lim[3] = d;
  endtask

  initial begin
    #1_000_000;
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    clear_queues();
    set_lim(4, 4, 4, 4);
    push(0, 20, 0);
    push(4, 21, 0);
    present();
    rt_ctrl = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset clears every output even with live heads
    chk("R1", "slot_vld in reset", int'(slot_vld), 0);
    chk("R1", "pop_cnt in reset", int'(pop_cnt), 0);
    chk("R1", "free_inc in reset", int'(free_inc), 0);
    chk("R1", "rt_cls in reset", int'(rt_cls), 0);
    rst = 1'b0;
    rt_ctrl = 1'b0;
    // R11: nothing appears until the next edge has sampled the heads
    chk("R11", "slot_vld before edge", int'(slot_vld), 0);
    model();
    @(posedge clk); #1;
    chk("R11", "slot0 after edge", int'(slot_seq[0 +: SEQ_W]), 20);
    compare();
    apply_pops();

    // R4: equal ages resolve by queue order
    clear_queues(); set_lim(1, 1, 1, 1);
    push(4, 10, 0); push(1, 10, 0); push(0, 10, 0);
    run_cycle();
    chk("R4", "tie slot0 class", int'(slot_cls[0 +: CLS_W]), 0);
    chk("R4", "tie slot1 class", int'(slot_cls[CLS_W +: CLS_W]), 1);
    chk("R4", "tie slot2 class", int'(slot_cls[2*CLS_W +: CLS_W]), 4);

    // R9: sentinel heads never issue
    clear_queues(); set_lim(4, 4, 4, 4);
    push(0, SENT, 0); push(4, SENT, 0);
    run_cycle();
    chk("R9", "sentinel slot_vld", int'(slot_vld), 0);
    chk("R9", "sentinel pop int", int'(pop_cnt[0 +: PTR_W]), 0);

    // R5: a zero cap blocks an older integer head
    clear_queues(); set_lim(0, 4, 4, 4);
    push(0, 1, 0); push(0, 2, 0); push(0, 3, 0); push(1, 9, 0);
    run_cycle();
    chk("R5", "blocked int count", int'(cls_cnt[0 +: CNT_W]), 0);
    chk("R5", "fp issues instead", int'(slot_seq[0 +: SEQ_W]), 9);

    // R6: misc fills the full width with all caps at zero
    clear_queues(); set_lim(0, 0, 0, 0);
    push(4, 1, 0); push(4, 2, 0); push(4, 3, 0); push(4, 4, 0); push(5, 5, 0);
    run_cycle();
    chk("R6", "misc count", int'(cls_cnt[4*CNT_W +: CNT_W]), 4);
    chk("R6", "total bounds misc", int'(free_inc), 4);

    // R7: squashed heads vanish without using width
    clear_queues(); set_lim(4, 4, 4, 4);
    push(0, 1, 1); push(0, 2, 1); push(0, 7, 0); push(1, 8, 0);
    run_cycle();
    chk("R7", "stall count", int'(stall_cnt), 2);
    chk("R7", "int popped", int'(pop_cnt[0 +: PTR_W]), 3);
    chk("R7", "live after squash", int'(slot_seq[0 +: SEQ_W]), 7);

    // R8: older drain entry takes slot 0 with class 5
    clear_queues();
    push(5, 3, 1); push(0, 4, 0);
    run_cycle();
    chk("R8", "drain class", int'(slot_cls[0 +: CLS_W]), 5);
    chk("R8", "drain seq", int'(slot_seq[0 +: SEQ_W]), 3);
    chk("R8", "drain counts width", int'(free_inc), 2);

    // random sweep against the model (R2, R3, R5, R6, R7, R8)
    clear_queues();
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (cyc % 50 == 0)
        set_lim(int'($urandom % 5), int'($urandom % 5), int'($urandom % 5), int'($urandom % 5));
      for (int q = 0; q < NQ; q++)
        while (qlen[q] < LOOK + 2 && ($urandom % 3) != 0) begin
          int sq;
          sq = ($urandom % 32 == 0) ? SENT : int'($urandom % SENT);
          push(q, sq, ($urandom % 5) == 0);
        end
      run_cycle();
      // a stuck sentinel head would block its queue forever; drop it
      for (int q = 0; q < NQ; q++)
        if (qlen[q] > 0 && qs[q][0] == SENT && ($urandom % 4) == 0) begin
          for (int k = 0; k < QMAX-1; k++) begin qs[q][k] = qs[q][k+1]; qsq[q][k] = qsq[q][k+1]; end
          qlen[q]--;
        end
    end

    // R10: router over all flag combinations
    for (int v = 0; v < 16; v++) begin
      int ex;
      rt_ctrl = v[0]; rt_mem = v[1]; rt_int = v[2]; rt_fp = v[3];
      ex = v[0] ? 2 : v[1] ? 3 : v[2] ? 0 : v[3] ? 1 : 4;
      @(posedge clk); #1;
      chk("R10", $sformatf("route flags %0d", v), int'(rt_cls), ex);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule